// File: doc/BRIEF.md
# Dual-Converter Synchronized Trigger Sequencer

This block sits between a trigger fabric and two analog-to-digital converter cores: converter A, the master, and converter B, the slave. A single routine trigger is picked from a bank of trigger lines. It launches a conversion round. The round's start pattern comes from a 2-bit mode field. In the parallel pattern both cores start together. In the fast follow-up pattern B starts first and A starts a fixed 7 cycles later. In the slow follow-up pattern B starts first, A starts 14 cycles later, and B starts once more after another 14 cycles.

The cores are seen only as start pulses going out and done strobes with result words coming back. Each done strobe arrives some latency after its start. When the master core finishes, the block places both results into one 32-bit word. The slave result goes in the upper half and the master result in the lower half. If end-of-conversion is enabled, the block then raises an interrupt flag and a DMA request. The block can re-arm by itself for continuous conversion. It records dropped triggers and unread results in a sticky overrun flag. It refuses fast follow-up rounds when the sampling time is too long for the 7-cycle gap.

Top module: `dual_adc_seq`

## Requirements
- R1: A trigger event is `trig_in[cfg_trig_sel]` high at a rising clock edge while the block is idle. High levels on the other trigger lines start nothing.
- R2: Mode 2'b01 (parallel) drives `a_start` and `b_start` together, each for one cycle, in the cycle right after the trigger edge.
- R3: Mode 2'b10 (fast follow-up) pulses `b_start` in the cycle after the trigger edge and pulses `a_start` exactly 7 cycles after that.
- R4: Mode 2'b11 (slow follow-up) pulses `b_start` at cycle k after the trigger, `a_start` at k+14, and `b_start` again at k+28. A round ends once every started conversion has reported done.
- R5: With `cfg_cont` high, a finished round starts the next round with the same pattern and needs no new trigger. Rounds stop once `cfg_cont` is low at the end of a round.
- R6: One cycle after `a_done`, `pack_data` holds the A result, zero-extended, in bits [15:0]. Bits [31:16] hold the newest B result that arrived at or before that done, also zero-extended.
- R7: `a_done` with `cfg_eoc_ie` high sets `irq` and `dma_req` on the next cycle. With `cfg_eoc_ie` low neither is set, but `pack_data` still updates. `irq_clr` clears `irq`.
- R8: `dma_ack` clears `dma_req` on the next cycle. A new enabled result that arrives while `dma_req` is still pending overwrites `pack_data` and sets `ovr_flag`.
- R9: A trigger that arrives while a round is active is dropped and sets the sticky `ovr_flag`. `ovr_clr` clears the flag.
- R10: `cfg_err` is high when the mode is fast follow-up and `cfg_samp` is 7 or more. A trigger in that state starts nothing.
- R11: In mode 2'b00 triggers are ignored. If the mode changes while a round is active, the running round keeps the pattern it latched at its trigger.
- R12: After reset, `busy`, both start outputs, `dma_req`, `irq`, `ovr_flag`, `cfg_err` and `pack_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | 8 | Candidate trigger lines |
| cfg_trig_sel | input | 3 | Index of the trigger line in use |
| cfg_mode | input | 2 | 00 idle, 01 parallel, 10 fast follow-up, 11 slow follow-up |
| cfg_cont | input | 1 | Continuous re-arm enable |
| cfg_samp | input | 4 | Sampling time in cycles, used for the fast-mode check |
| cfg_eoc_ie | input | 1 | End-of-conversion interrupt and DMA enable |
| a_done | input | 1 | Master conversion finished strobe |
| a_data | input | 12 | Master result |
| b_done | input | 1 | Slave conversion finished strobe |
| b_data | input | 12 | Slave result |
| dma_ack | input | 1 | DMA has taken the packed word |
| irq_clr | input | 1 | Write-one clear of the interrupt flag |
| ovr_clr | input | 1 | Write-one clear of the overrun flag |
| a_start | output | 1 | Master start pulse |
| b_start | output | 1 | Slave start pulse |
| busy | output | 1 | Round in progress |
| cfg_err | output | 1 | Fast follow-up sampling time too long |
| pack_data | output | 32 | Packed slave/master result word |
| dma_req | output | 1 | Packed word ready for DMA |
| irq | output | 1 | Sticky end-of-conversion interrupt flag |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
The properties assume the converter cores behave: a done strobe arrives only for a conversion that is still pending, never in the cycle of its own start, and the latency is short enough that the slave's first result returns before its second start in the slow pattern. The bench converter models keep to this by drawing latencies from 1 to 12 cycles. They raise each done once per start. The stimulus fires triggers only when idle, except in the directed overrun case. Sampling times are drawn below 7 except in the case that tests the configuration-error refusal.

// File: rtl/das_pkg.sv
package das_pkg;

   typedef enum logic [1:0] {
      DAS_IDLE = 2'b00,
      DAS_PAR  = 2'b01,
      DAS_FAST = 2'b10,
      DAS_SLOW = 2'b11
   } das_mode_e;

   localparam int unsigned DAS_WORD_W = 32;

endpackage

// File: rtl/das_trig_pick.sv
module das_trig_pick #(
   parameter int unsigned N_TRIG = 8,
   parameter int unsigned SEL_W  = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
   input  logic [N_TRIG-1:0] trig_in,
   input  logic [SEL_W-1:0]  sel,
   output logic              evt
);

   logic [N_TRIG-1:0] hit;

   if (N_TRIG < 1 || N_TRIG > (1 << SEL_W)) begin : g_bad_cfg
      $error("das_trig_pick: N_TRIG does not fit the select width");
   end

   for (genvar i = 0; i < N_TRIG; i++) begin : g_line
      assign hit[i] = trig_in[i] && (sel == SEL_W'(i));
   end

   assign evt = |hit;

endmodule

// File: rtl/das_sched.sv
module das_sched
   import das_pkg::*;
#(
   parameter int unsigned FAST_GAP = 7,
   parameter int unsigned SLOW_GAP = 14,
   parameter int unsigned PEND_W   = 2,
   localparam int unsigned LAST_MAX = 2 * SLOW_GAP,
   localparam int unsigned TMR_W    = $clog2(LAST_MAX + 2)
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      launch,
   input  das_mode_e mode_in,
   input  logic      cont,
   input  logic      a_done,
   input  logic      b_done,
   output logic      busy,
   output das_mode_e run_mode,
   output logic      a_start,
   output logic      b_start
);

   logic              active;
   das_mode_e         mode_q;
   logic [TMR_W-1:0]  tmr;
   logic [TMR_W-1:0]  last_slot;
   logic [TMR_W-1:0]  a_slot;
   logic [PEND_W-1:0] a_pend;
   logic [PEND_W-1:0] b_pend;
   logic              sched_over;
   logic              round_end;
   logic              a_dec;
   logic              b_dec;

   if (PEND_W < 2) begin : g_bad_pend
      $error("das_sched: PEND_W must hold two outstanding slave conversions");
   end

   always_comb begin
      unique case (mode_q)
         DAS_PAR: begin
            last_slot = '0;
            a_slot    = '0;
         end
         DAS_FAST: begin
            last_slot = TMR_W'(FAST_GAP);
            a_slot    = TMR_W'(FAST_GAP);
         end
         DAS_SLOW: begin
            last_slot = TMR_W'(LAST_MAX);
            a_slot    = TMR_W'(SLOW_GAP);
         end
         default: begin
            last_slot = '0;
            a_slot    = '0;
         end
      endcase
   end

   assign b_start = active && ((tmr == '0) ||
                    ((mode_q == DAS_SLOW) && (tmr == TMR_W'(LAST_MAX))));
   assign a_start = active && (tmr == a_slot);

   assign sched_over = active && (tmr == last_slot + TMR_W'(1));
   assign round_end  = sched_over && (a_pend == '0) && (b_pend == '0);
   assign a_dec      = a_done && (a_pend != '0);
   assign b_dec      = b_done && (b_pend != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         mode_q <= DAS_IDLE;
         tmr    <= '0;
      end else if (!active) begin
         if (launch) begin
            active <= 1'b1;
            mode_q <= mode_in;
            tmr    <= '0;
         end
      end else if (!sched_over) begin
         tmr <= tmr + TMR_W'(1);
      end else if (round_end) begin
         if (cont) begin
            tmr <= '0;
         end else begin
            active <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_pend <= '0;
         b_pend <= '0;
      end else begin
         a_pend <= a_pend + PEND_W'(a_start) - PEND_W'(a_dec);
         b_pend <= b_pend + PEND_W'(b_start) - PEND_W'(b_dec);
      end
   end

   assign busy     = active;
   assign run_mode = mode_q;

endmodule

// File: rtl/das_pack.sv
module das_pack #(
   parameter int unsigned DW   = 12,
   parameter int unsigned HALF = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            a_done,
   input  logic [DW-1:0]   a_data,
   input  logic            b_done,
   input  logic [DW-1:0]   b_data,
   input  logic            eoc_ie,
   input  logic            dma_ack,
   input  logic            irq_clr,
   output logic [2*HALF-1:0] pack_data,
   output logic            dma_req,
   output logic            irq,
   output logic            overwrite
);

   logic [DW-1:0]   b_hold;
   logic [DW-1:0]   b_now;
   logic [HALF-1:0] a_ext;
   logic [HALF-1:0] b_ext;
   logic            new_evt;

   if (DW < 1 || DW > HALF) begin : g_bad_dw
      $error("das_pack: result width must fit one half of the packed word");
   end

   assign b_now = b_done ? b_data : b_hold;

   if (DW < HALF) begin : g_pad
      assign a_ext = {{(HALF - DW){1'b0}}, a_data};
      assign b_ext = {{(HALF - DW){1'b0}}, b_now};
   end else begin : g_full
      assign a_ext = a_data;
      assign b_ext = b_now;
   end

   assign new_evt   = a_done && eoc_ie;
   assign overwrite = new_evt && dma_req && !dma_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_hold    <= '0;
         pack_data <= '0;
      end else begin
         if (b_done) begin
            b_hold <= b_data;
         end
         if (a_done) begin
            pack_data <= {b_ext, a_ext};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dma_req <= 1'b0;
         irq     <= 1'b0;
      end else begin
         if (new_evt) begin
            dma_req <= 1'b1;
         end else if (dma_ack) begin
            dma_req <= 1'b0;
         end
         if (new_evt) begin
            irq <= 1'b1;
         end else if (irq_clr) begin
            irq <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/dual_adc_seq.sv
module dual_adc_seq
   import das_pkg::*;
#(
   parameter int unsigned N_TRIG   = 8,
   parameter int unsigned DW       = 12,
   parameter int unsigned SAMP_W   = 4,
   parameter int unsigned FAST_GAP = 7,
   parameter int unsigned SLOW_GAP = 14,
   localparam int unsigned SEL_W   = (N_TRIG > 1) ? $clog2(N_TRIG) : 1,
   localparam int unsigned HALF    = DAS_WORD_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_TRIG-1:0] trig_in,
   input  logic [SEL_W-1:0]  cfg_trig_sel,
   input  logic [1:0]        cfg_mode,
   input  logic              cfg_cont,
   input  logic [SAMP_W-1:0] cfg_samp,
   input  logic              cfg_eoc_ie,
   input  logic              a_done,
   input  logic [DW-1:0]     a_data,
   input  logic              b_done,
   input  logic [DW-1:0]     b_data,
   input  logic              dma_ack,
   input  logic              irq_clr,
   input  logic              ovr_clr,
   output logic              a_start,
   output logic              b_start,
   output logic              busy,
   output logic              cfg_err,
   output logic [DAS_WORD_W-1:0] pack_data,
   output logic              dma_req,
   output logic              irq,
   output logic              ovr_flag
);

   das_mode_e mode_sel;
   das_mode_e run_mode;
   logic      trig_evt;
   logic      launch;
   logic      drop;
   logic      overwrite;

   if (FAST_GAP < 1 || SLOW_GAP <= FAST_GAP) begin : g_bad_gap
      $error("dual_adc_seq: gaps must satisfy 0 < FAST_GAP < SLOW_GAP");
   end
   if ((1 << SAMP_W) <= FAST_GAP) begin : g_bad_samp
      $error("dual_adc_seq: SAMP_W too narrow to express the fast-mode limit");
   end

   assign mode_sel = das_mode_e'(cfg_mode);

   das_trig_pick #(
      .N_TRIG (N_TRIG),
      .SEL_W  (SEL_W)
   ) u_pick (
      .trig_in (trig_in),
      .sel     (cfg_trig_sel),
      .evt     (trig_evt)
   );

   assign cfg_err = (mode_sel == DAS_FAST) && (cfg_samp >= SAMP_W'(FAST_GAP));
   assign launch  = trig_evt && !busy && (mode_sel != DAS_IDLE) && !cfg_err;
   assign drop    = trig_evt && busy;

   das_sched #(
      .FAST_GAP (FAST_GAP),
      .SLOW_GAP (SLOW_GAP),
      .PEND_W   (2)
   ) u_sched (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .mode_in  (mode_sel),
      .cont     (cfg_cont),
      .a_done   (a_done),
      .b_done   (b_done),
      .busy     (busy),
      .run_mode (run_mode),
      .a_start  (a_start),
      .b_start  (b_start)
   );

   das_pack #(
      .DW   (DW),
      .HALF (HALF)
   ) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .a_done    (a_done),
      .a_data    (a_data),
      .b_done    (b_done),
      .b_data    (b_data),
      .eoc_ie    (cfg_eoc_ie),
      .dma_ack   (dma_ack),
      .irq_clr   (irq_clr),
      .pack_data (pack_data),
      .dma_req   (dma_req),
      .irq       (irq),
      .overwrite (overwrite)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_flag <= 1'b0;
      end else if (drop || overwrite) begin
         ovr_flag <= 1'b1;
      end else if (ovr_clr) begin
         ovr_flag <= 1'b0;
      end
   end

endmodule

// File: rtl/das_chk.sv
module das_chk
   import das_pkg::*;
#(
   parameter int unsigned N_TRIG   = 8,
   parameter int unsigned DW       = 12,
   parameter int unsigned FAST_GAP = 7,
   parameter int unsigned SLOW_GAP = 14,
   localparam int unsigned SEL_W   = (N_TRIG > 1) ? $clog2(N_TRIG) : 1,
   localparam int unsigned CW      = $clog2(2 * SLOW_GAP + 4)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_TRIG-1:0] trig_in,
   input logic [SEL_W-1:0]  cfg_trig_sel,
   input logic [1:0]        cfg_mode,
   input logic              cfg_err,
   input logic              cfg_eoc_ie,
   input logic              busy,
   input logic [1:0]        run_mode,
   input logic              a_start,
   input logic              b_start,
   input logic              a_done,
   input logic [DW-1:0]     a_data,
   input logic              dma_req,
   input logic              dma_ack,
   input logic              irq,
   input logic              ovr_flag,
   input logic [31:0]       pack_data
);

   logic [CW-1:0] since_b;
   logic          trig_evt;

   assign trig_evt = trig_in[cfg_trig_sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_b <= '0;
      end else if (b_start) begin
         since_b <= CW'(1);
      end else if (since_b != '1) begin
         since_b <= since_b + CW'(1);
      end
   end

   p_par_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (b_start && run_mode == DAS_PAR) |-> a_start);

   p_fast_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (a_start && run_mode == DAS_FAST) |-> (since_b == CW'(FAST_GAP)));

   p_slow_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (a_start && run_mode == DAS_SLOW) |-> (since_b == CW'(SLOW_GAP)));

   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (a_start || b_start) |-> busy);

   p_pack_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      a_done |=> (pack_data[DW-1:0] == $past(a_data)));

   p_eoc_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (a_done && cfg_eoc_ie) |=> (dma_req && irq));

   p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req && dma_ack && !(a_done && cfg_eoc_ie)) |=> !dma_req);

   p_drop_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && trig_evt) |=> ovr_flag);

   p_err_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cfg_err) |=> !busy);

   p_idle_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cfg_mode == DAS_IDLE) |=> !busy);

endmodule

bind dual_adc_seq das_chk #(
   .N_TRIG   (N_TRIG),
   .DW       (DW),
   .FAST_GAP (FAST_GAP),
   .SLOW_GAP (SLOW_GAP)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .trig_in      (trig_in),
   .cfg_trig_sel (cfg_trig_sel),
   .cfg_mode     (cfg_mode),
   .cfg_err      (cfg_err),
   .cfg_eoc_ie   (cfg_eoc_ie),
   .busy         (busy),
   .run_mode     (run_mode),
   .a_start      (a_start),
   .b_start      (b_start),
   .a_done       (a_done),
   .a_data       (a_data),
   .dma_req      (dma_req),
   .dma_ack      (dma_ack),
   .irq          (irq),
   .ovr_flag     (ovr_flag),
   .pack_data    (pack_data)
);

// File: tb/dual_adc_seq_test.sv
module dual_adc_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  trig_in = '0;
   logic [2:0]  cfg_trig_sel = '0;
   logic [1:0]  cfg_mode = '0;
   logic        cfg_cont = 1'b0;
   logic [3:0]  cfg_samp = '0;
   logic        cfg_eoc_ie = 1'b0;
   logic        a_done = 1'b0;
   logic [11:0] a_data = '0;
   logic        b_done = 1'b0;
   logic [11:0] b_data = '0;
   logic        dma_ack = 1'b0;
   logic        irq_clr = 1'b0;
   logic        ovr_clr = 1'b0;
   logic        a_start, b_start, busy, cfg_err, dma_req, irq, ovr_flag;
   logic [31:0] pack_data;

   int          cyc = 0;
   int          checks = 0;
   int          errs = 0;
   bit          finished = 1'b0;
   int          a_lat = 3, b_lat = 3;
   int          a_cd = 0, b_cd = 0;
   logic [11:0] b_last = '0;
   logic [31:0] exp_pack = '0;
   int          a_t[16];
   int          b_t[16];
   int          na = 0, nb = 0;
   int          t0 = 0;

   always #10 clk = ~clk;

   dual_adc_seq uut (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .cfg_trig_sel(cfg_trig_sel),
      .cfg_mode(cfg_mode), .cfg_cont(cfg_cont), .cfg_samp(cfg_samp),
      .cfg_eoc_ie(cfg_eoc_ie), .a_done(a_done), .a_data(a_data),
      .b_done(b_done), .b_data(b_data), .dma_ack(dma_ack), .irq_clr(irq_clr),
      .ovr_clr(ovr_clr), .a_start(a_start), .b_start(b_start), .busy(busy),
      .cfg_err(cfg_err), .pack_data(pack_data), .dma_req(dma_req), .irq(irq),
      .ovr_flag(ovr_flag)
   );

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [31:0] pack_of(logic [11:0] b, logic [11:0] a);
      return {4'h0, b, 4'h0, a};
   endfunction

   function automatic int a_off(logic [1:0] m);
      return (m == 2'b01) ? 1 : (m == 2'b10) ? 8 : 15;
   endfunction

   function automatic int b_cnt(logic [1:0] m);
      return (m == 2'b11) ? 2 : 1;
   endfunction

   // Converter models and start recorder.
   always @(negedge clk) begin
      logic [11:0] v;
      a_done = 1'b0;
      b_done = 1'b0;
      if (b_cd != 0) begin
         if (b_cd == 1) begin
            v = 12'($urandom);
            b_done = 1'b1;
            b_data = v;
            b_last = v;
         end
         b_cd = b_cd - 1;
      end
      if (a_cd != 0) begin
         if (a_cd == 1) begin
            v = 12'($urandom);
            a_done = 1'b1;
            a_data = v;
            exp_pack = pack_of(b_last, v);
         end
         a_cd = a_cd - 1;
      end
      if (b_start) begin
         b_cd = b_lat;
         if (nb < 16) b_t[nb] = cyc;
         nb++;
      end
      if (a_start) begin
         a_cd = a_lat;
         if (na < 16) a_t[na] = cyc;
         na++;
      end
   end

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic fire(int line);
      @(negedge clk);
      na = 0;
      nb = 0;
      trig_in = 8'(1 << line);
      t0 = cyc;
      @(negedge clk);
      trig_in = '0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 300) begin
         @(negedge clk);
         n++;
      end
      if (busy) chk(1'b0, "R4 round completion", 32'(busy), 32'h0);
      repeat (2) @(negedge clk);
   endtask

   task automatic clear_all();
      @(negedge clk);
      dma_ack = 1'b1;
      irq_clr = 1'b1;
      ovr_clr = 1'b1;
      @(negedge clk);
      dma_ack = 1'b0;
      irq_clr = 1'b0;
      ovr_clr = 1'b0;
   endtask

   task automatic run_round(logic [1:0] m, int line, string tag);
      cfg_mode = m;
      cfg_trig_sel = 3'(line);
      fire(line);
      wait_idle();
      chk(nb == b_cnt(m), {tag, " slave start count"}, 32'(nb), 32'(b_cnt(m)));
      chk(na == 1, {tag, " master start count"}, 32'(na), 32'h1);
      chk(b_t[0] == t0 + 1, {tag, " slave start cycle"}, 32'(b_t[0] - t0), 32'h1);
      chk(a_t[0] == t0 + a_off(m), {tag, " master start cycle"},
          32'(a_t[0] - t0), 32'(a_off(m)));
      if (m == 2'b11)
         chk(b_t[1] == t0 + 29, {tag, " second slave start"}, 32'(b_t[1] - t0), 32'd29);
      chk(pack_data == exp_pack, "R6 packed word", pack_data, exp_pack);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errs++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errs);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (4) @(negedge clk);
      // R12 reset state
      chk({busy, a_start, b_start, dma_req, irq, ovr_flag, cfg_err} == '0,
          "R12 flags after reset", 32'({busy, a_start, b_start, dma_req, irq, ovr_flag, cfg_err}), 32'h0);
      chk(pack_data == '0, "R12 packed word after reset", pack_data, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 parallel on line 3
      cfg_eoc_ie = 1'b1;
      run_round(2'b01, 3, "R2");
      chk(dma_req && irq, "R7 flags after enabled eoc", 32'({dma_req, irq}), 32'h3);

      // R8 acknowledge clears request
      @(negedge clk); dma_ack = 1'b1;
      @(negedge clk); dma_ack = 1'b0;
      chk(!dma_req, "R8 ack clears request", 32'(dma_req), 32'h0);

      // R1 wrong line starts nothing
      cfg_trig_sel = 3'd3;
      @(negedge clk); na = 0; nb = 0; trig_in = 8'b1111_0111;
      @(negedge clk); trig_in = '0;
      repeat (20) @(negedge clk);
      chk(na == 0 && nb == 0 && !busy, "R1 unselected lines ignored", 32'(na + nb), 32'h0);

      // R3 fast follow-up
      a_lat = 5; b_lat = 2;
      run_round(2'b10, 5, "R3");

      // R4 slow follow-up with R11 mode change mid-round
      cfg_mode = 2'b11; cfg_trig_sel = 3'd0;
      fire(0);
      cfg_mode = 2'b01;
      wait_idle();
      chk(a_t[0] == t0 + 15, "R11 latched mode kept (R4 master slot)", 32'(a_t[0] - t0), 32'd15);
      chk(nb == 2 && b_t[1] == t0 + 29, "R4 second slave start", 32'(b_t[1] - t0), 32'd29);
      chk(pack_data == exp_pack, "R6 slow pack uses first slave result", pack_data, exp_pack);

      // R9 trigger during round
      clear_all();
      cfg_mode = 2'b10; cfg_trig_sel = 3'd2;
      fire(2);
      repeat (2) @(negedge clk);
      trig_in = 8'h04;
      @(negedge clk); trig_in = '0;
      wait_idle();
      chk(nb == 1 && na == 1, "R9 dropped trigger adds no start", 32'(nb), 32'h1);
      chk(ovr_flag, "R9 overrun set on drop", 32'(ovr_flag), 32'h1);
      @(negedge clk); ovr_clr = 1'b1; dma_ack = 1'b1;
      @(negedge clk); ovr_clr = 1'b0; dma_ack = 1'b0;
      chk(!ovr_flag, "R9 overrun cleared", 32'(ovr_flag), 32'h0);

      // R8 overwrite without ack
      run_round(2'b01, 2, "R8 first");
      chk(!ovr_flag && dma_req, "R8 pending before overwrite", 32'({ovr_flag, dma_req}), 32'h1);
      run_round(2'b01, 2, "R8 second");
      chk(ovr_flag && dma_req, "R8 overwrite sets overrun", 32'({ovr_flag, dma_req}), 32'h3);

      // R7 disabled eoc
      clear_all();
      cfg_eoc_ie = 1'b0;
      run_round(2'b10, 1, "R7");
      chk(!irq && !dma_req, "R7 no flags when disabled", 32'({irq, dma_req}), 32'h0);
      cfg_eoc_ie = 1'b1;

      // R10 configuration error
      cfg_mode = 2'b10; cfg_samp = 4'd7; cfg_trig_sel = 3'd4;
      @(negedge clk);
      chk(cfg_err, "R10 error flagged at 7", 32'(cfg_err), 32'h1);
      fire(4);
      repeat (15) @(negedge clk);
      chk(na == 0 && nb == 0 && !busy, "R10 trigger refused", 32'(na + nb), 32'h0);
      cfg_samp = 4'd6;
      @(negedge clk);
      chk(!cfg_err, "R10 no error at 6", 32'(cfg_err), 32'h0);

      // R11 idle mode ignores triggers
      cfg_mode = 2'b00;
      fire(4);
      repeat (15) @(negedge clk);
      chk(na == 0 && nb == 0 && !busy, "R11 idle mode ignores trigger", 32'(na + nb), 32'h0);

      // R5 continuous fast follow-up
      begin
         int n = 0;
         cfg_mode = 2'b10; cfg_cont = 1'b1;
         fire(4);
         while (nb < 3 && n < 400) begin @(negedge clk); n++; end
         cfg_cont = 1'b0;
         wait_idle();
         chk(nb >= 3, "R5 rounds repeat without trigger", 32'(nb), 32'h3);
         for (int i = 0; i < 3; i++)
            chk(a_t[i] - b_t[i] == 7, "R5 gap in each round", 32'(a_t[i] - b_t[i]), 32'd7);
      end

      // Random rounds
      for (int it = 0; it < 40; it++) begin
         logic [1:0] m;
         int ln;
         logic ie;
         m = 2'(1 + $urandom % 3);
         ln = int'($urandom % 8);
         ie = 1'($urandom);
         a_lat = 1 + int'($urandom % 12);
         b_lat = 1 + int'($urandom % 12);
         cfg_samp = 4'($urandom % 7);
         cfg_eoc_ie = ie;
         clear_all();
         run_round(m, ln, "R2/R3/R4 random");
         chk(irq == ie && dma_req == ie, "R7 random flags", 32'({irq, dma_req}), 32'({ie, ie}));
         chk(!ovr_flag, "R9 no spurious overrun", 32'(ovr_flag), 32'h0);
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
   end

endmodule